// File: doc/BRIEF.md
# Serial Sampling Converter Port Emulator

This block reproduces, in synthesizable logic, the digital behaviour of a 12-bit sampling converter seen through a three-wire port: a convert strobe, a serial clock and a data line that can float. A parallel word on `sample_i` stands in for the analog result. The word is latched when the convert strobe falls. Leaving sample mode follows that strobe edge, not the serial clock. The block runs on a fast system clock. It samples both port lines through synchronizers and acts on their edges.

After a conversion starts, the first serial clock fall drives a LOW start bit. The next twelve falls present the two's-complement result, most significant bit first. The level of the convert strobe at given clock counts picks what follows:
- power-down, if the strobe stays LOW.
- a full-power finish, if the strobe is raised and stays HIGH.
- an LSB-first replay of the word, if the strobe is raised and then lowered during the 13th clock.
- an early abort, if the strobe is raised and then lowered before that clock.

Flags report hold mode and low-power mode. The `data_oe_o` output models the floating data pin.

Top module: `serial_adc_emu`

## Requirements
- R1: While reset is asserted, and right after it, `data_oe_o`, `pwr_down_o` and `hold_o` are 0.
- R2: A falling edge on `conv_i` in sample mode sets `hold_o` to 1 and latches `sample_i`. Changes on `sample_i` after that edge do not alter the bits shifted out.
- R3: The first `sclk_i` fall after the conversion starts sets `data_oe_o` to 1 and drives `data_o` LOW. Falls 2 to 13 present bits 11 down to 0 of the latched word, one bit per fall.
- R4: The word is sent unchanged in two's complement, including the codes 0x7FF (largest), 0x800 (most negative) and 0xFFF (one step below mid-scale).
- R5: If `conv_i` stays LOW from the start, `pwr_down_o` rises at the 13th fall while bit 0 is still driven. At the 14th fall `data_oe_o` drops to 0 and the block stays powered down.
- R6: A rising edge on `conv_i` during power-down returns the block to sample mode: `pwr_down_o`, `hold_o` and `data_oe_o` all become 0.
- R7: If `conv_i` rises during clocks 1 to 12 and is still HIGH at the 14th fall, all bits are sent. At that 14th fall `data_oe_o` and `hold_o` go to 0 and `pwr_down_o` stays 0.
- R8: If `conv_i` rises during clocks 1 to 12 and then falls during the 13th clock, bit 0 remains driven and `pwr_down_o` becomes 1. Falls 14 to 24 then present bits 1 to 11. A strobe fall in the same system cycle as the 13th clock fall counts as falling during the 13th clock.
- R9: After the LSB-first replay, `data_o` is driven LOW with `data_oe_o` at 1 until `conv_i` rises. The rise ends the replay and returns the block to sample mode.
- R10: If `conv_i` rises during the conversion and falls again before the 13th clock fall, `data_oe_o` drops to 0 at once and `pwr_down_o` becomes 1. Later `sclk_i` falls leave `data_oe_o` at 0.
- R11: In sample mode, `sclk_i` edges are ignored: `data_oe_o` and `hold_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; must run much faster than `sclk_i` |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_i | input | 1 | Convert strobe (asynchronous) |
| sclk_i | input | 1 | Serial clock of the converter port (asynchronous) |
| sample_i | input | 12 | Parallel word standing in for the analog result |
| data_o | output | 1 | Serial data bit, meaningful while `data_oe_o` is 1 |
| data_oe_o | output | 1 | Data pin driven (1) or floating (0) |
| pwr_down_o | output | 1 | Low-power mode flag |
| hold_o | output | 1 | Hold mode (1) or sample mode (0) |

## Verification
The conflict that needs care is a convert-strobe fall that arrives in the same system cycle as the 13th serial clock fall, after the strobe was raised mid-conversion. That one event could be read as the strobe dropping during clock 13, which starts an LSB-first replay, or as a fall just before that clock, which is a short-cycle abort. The bench provokes it by driving both lines low at the same system clock edge. It requires the replay reading: bit 0 stays on the line, power-down is flagged, and bit 1 appears on the next clock fall. The same scenario is also run with the strobe falling several cycles after the clock fall, and both runs must give the same result.

// File: rtl/serial_adc_emu_pkg.sv
package serial_adc_emu_pkg;

  // Port sequencer states
  typedef enum logic [2:0] {
    ST_SAMPLE,   // tracking input, data floating
    ST_CONV,     // converting, strobe held low since start
    ST_ARMED,    // converting, strobe raised mid-conversion
    ST_LSB,      // LSB-first replay, low power
    ST_PD        // powered down, data floating
  } emu_state_e;

endpackage

// File: rtl/serial_adc_emu_sync.sv
module serial_adc_emu_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic lvl_o,
  output logic prv_o
);

  logic [STAGES-1:0] chain_q;
  logic              prv_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prv_q <= RST_VAL;
    else         prv_q <= chain_q[STAGES-1];
  end

  assign lvl_o = chain_q[STAGES-1];
  assign prv_o = prv_q;

endmodule

// File: rtl/serial_adc_emu_bitsel.sv
module serial_adc_emu_bitsel #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 5
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              lsb_i,
  output logic              bit_o
);

  // Clock number that carries bit 0 in the MSB-first order
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(DATA_W + 1);

  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (cnt_i == LAST_C - CNT_W'(i)) bit_o = word_i[i];
      if (lsb_i && (i > 0) && (cnt_i == LAST_C + CNT_W'(i))) bit_o = word_i[i];
    end
  end

endmodule

// File: rtl/serial_adc_emu_ctrl.sv
module serial_adc_emu_ctrl
  import serial_adc_emu_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_lvl_i,
  input  logic              conv_prv_i,
  input  logic              sclk_lvl_i,
  input  logic              sclk_prv_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              data_o,
  output logic              oe_o,
  output logic              pd_o,
  output logic              hold_o
);

  localparam int CNT_MAX_I = 2 * DATA_W + 1;
  localparam int CNT_W     = $clog2(CNT_MAX_I + 1);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] END_C   = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CNT_MAX_I);

  emu_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc, cnt_pos;
  logic [DATA_W-1:0] word_q, word_d;
  logic              data_q, data_d;
  logic              oe_q, oe_d;
  logic              pd_q, pd_d;
  logic              lsb_q, lsb_d;
  logic              data_upd;
  logic              bit_d;
  logic              conv_fall, conv_rise, sclk_fall, upd_en;

  assign conv_fall = conv_prv_i & ~conv_lvl_i;
  assign conv_rise = ~conv_prv_i & conv_lvl_i;
  assign sclk_fall = sclk_prv_i & ~sclk_lvl_i;
  assign upd_en    = conv_fall | conv_rise | sclk_fall;
  assign cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  serial_adc_emu_bitsel #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) i_bitsel (
    .word_i (word_q),
    .cnt_i  (cnt_d),
    .lsb_i  (lsb_d),
    .bit_o  (bit_d)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    word_d   = word_q;
    oe_d     = oe_q;
    pd_d     = pd_q;
    lsb_d    = lsb_q;
    data_upd = 1'b0;
    cnt_pos  = sclk_fall ? cnt_inc : cnt_q;

    unique case (state_q)
      ST_SAMPLE: begin
        if (conv_fall) begin
          state_d = ST_CONV;
          word_d  = sample_i;
          cnt_d   = '0;
          lsb_d   = 1'b0;
          oe_d    = 1'b0;
          pd_d    = 1'b0;
        end
      end

      ST_CONV: begin
        if (conv_rise && (cnt_q >= LAST_C)) begin
          // already powered down at the last bit: wake up
          state_d = ST_SAMPLE;
          oe_d    = 1'b0;
          pd_d    = 1'b0;
        end else begin
          if (conv_rise) state_d = ST_ARMED;
          if (sclk_fall) begin
            cnt_d    = cnt_inc;
            data_upd = 1'b1;
            oe_d     = 1'b1;
            if ((cnt_inc == LAST_C) && !conv_rise) pd_d = 1'b1;
            if (cnt_inc >= END_C) begin
              oe_d     = 1'b0;
              data_upd = 1'b0;
              state_d  = ST_PD;
            end
          end
        end
      end

      ST_ARMED: begin
        if (sclk_fall) begin
          cnt_d    = cnt_inc;
          data_upd = 1'b1;
          oe_d     = 1'b1;
        end
        if (conv_fall) begin
          pd_d = 1'b1;
          if (cnt_pos == LAST_C) begin
            // strobe dropped during the last bit: replay LSB first
            state_d = ST_LSB;
            lsb_d   = 1'b1;
          end else begin
            // short-cycle abort
            state_d  = ST_PD;
            oe_d     = 1'b0;
            data_upd = 1'b0;
          end
        end else if (sclk_fall && (cnt_inc >= END_C)) begin
          state_d  = ST_SAMPLE;
          oe_d     = 1'b0;
          data_upd = 1'b0;
        end
      end

      ST_LSB: begin
        if (conv_rise) begin
          state_d = ST_SAMPLE;
          oe_d    = 1'b0;
          pd_d    = 1'b0;
          lsb_d   = 1'b0;
        end else if (sclk_fall) begin
          cnt_d    = cnt_inc;
          data_upd = 1'b1;
        end
      end

      ST_PD: begin
        if (conv_rise) begin
          state_d = ST_SAMPLE;
          oe_d    = 1'b0;
          pd_d    = 1'b0;
        end
      end

      default: state_d = ST_SAMPLE;
    endcase

    data_d = data_upd ? bit_d : data_q;
  end

  // State registers, enabled only on a port edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SAMPLE;
      cnt_q   <= '0;
      word_q  <= '0;
      data_q  <= 1'b0;
      oe_q    <= 1'b0;
      pd_q    <= 1'b0;
      lsb_q   <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      word_q  <= word_d;
      data_q  <= data_d;
      oe_q    <= oe_d;
      pd_q    <= pd_d;
      lsb_q   <= lsb_d;
    end
  end

  assign data_o = data_q;
  assign oe_o   = oe_q;
  assign pd_o   = pd_q;
  assign hold_o = (state_q != ST_SAMPLE);

  // Sample mode never drives the pin nor sleeps (R11)
  assert_sample_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAMPLE) |-> (!oe_q && !pd_q));

  // Strobe fall latches the parallel word and enters hold (R2)
  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAMPLE && conv_fall) |=> (word_q == $past(sample_i) && hold_o));

  // First clock fall gives a driven LOW start bit (R3)
  assert_start_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && sclk_fall && cnt_q == '0 && !conv_rise) |=> (oe_q && !data_q));

  // Strobe rise wakes the block from any low-power state (R6)
  assert_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_rise && (state_q == ST_PD || state_q == ST_LSB))
      |=> (!pd_q && !oe_q && state_q == ST_SAMPLE));

  // Early strobe fall floats the pin and powers down (R10)
  assert_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && conv_fall && !sclk_fall && cnt_q < LAST_C) |=> (!oe_q && pd_q));

  // Power-down is only ever flagged while holding (R5)
  assert_pd_in_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q |-> (state_q != ST_SAMPLE));

endmodule

// File: rtl/serial_adc_emu.sv
module serial_adc_emu #(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              data_o,
  output logic              data_oe_o,
  output logic              pwr_down_o,
  output logic              hold_o
);

  localparam int N_LINES = 2;   // index 0: strobe, 1: serial clock

  logic               rst_meta_q, rst_sync_q;
  logic [N_LINES-1:0] line_raw, line_lvl, line_prv;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign line_raw = {sclk_i, conv_i};

  generate
    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
      serial_adc_emu_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
      ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_sync_q),
        .async_i (line_raw[g]),
        .lvl_o   (line_lvl[g]),
        .prv_o   (line_prv[g])
      );
    end
  endgenerate

  serial_adc_emu_ctrl #(
    .DATA_W (DATA_W)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .conv_lvl_i (line_lvl[0]),
    .conv_prv_i (line_prv[0]),
    .sclk_lvl_i (line_lvl[1]),
    .sclk_prv_i (line_prv[1]),
    .sample_i   (sample_i),
    .data_o     (data_o),
    .oe_o       (data_oe_o),
    .pd_o       (pwr_down_o),
    .hold_o     (hold_o)
  );

endmodule

// File: tb/test_serial_adc_emu.sv
module test_serial_adc_emu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        conv;
  logic        sclk;
  logic [11:0] sample;
  logic        data, oe, pd, hold;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  serial_adc_emu i_serial_adc_emu (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .conv_i     (conv),
    .sclk_i     (sclk),
    .sample_i   (sample),
    .data_o     (data),
    .data_oe_o  (oe),
    .pwr_down_o (pd),
    .hold_o     (hold)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sfall();
    sclk = 1'b0;
    wait_n(8);
  endtask

  task automatic srise();
    sclk = 1'b1;
    wait_n(8);
  endtask

  // Expected bit on clock k (1-based); lsb selects the replay order
  function automatic logic exp_bit(input logic [11:0] w, input int k, input bit lsb);
    if (k >= 2 && k <= 13) return w[13-k];
    if (lsb && k >= 14 && k <= 24) return w[k-13];
    return 1'b0;
  endfunction

  task automatic start_conv(input logic [11:0] w);
    sample = w;
    conv   = 1'b0;
    wait_n(6);
    chk("R2 hold after strobe fall", hold, 1);
    chk("R2 pin floating before clock 1", oe, 0);
    sample = ~w;   // must not reach the output
  endtask

  task automatic wake_check(input string req);
    conv = 1'b1;
    wait_n(6);
    chk({req, " pd cleared"}, pd, 0);
    chk({req, " hold cleared"}, hold, 0);
    chk({req, " pin floating"}, oe, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; conv = 1'b1; sclk = 1'b1; sample = '0;
    wait_n(4);
    chk("R1 oe in reset", oe, 0);
    chk("R1 pd in reset", pd, 0);
    chk("R1 hold in reset", hold, 0);
    rst_n = 1'b1;
    wait_n(10);
    chk("R1 oe after reset", oe, 0);
    chk("R1 hold after reset", hold, 0);
  endtask

  // Strobe held low: MSB-first readout then power-down (R3 R4 R5 R6 R11)
  task automatic t_normal(input logic [11:0] w);
    start_conv(w);
    for (int k = 1; k <= 13; k++) begin
      sfall();
      chk("R3 pin driven", oe, 1);
      chk("R3 R4 msb-first bit", data, exp_bit(w, k, 1'b0));
      chk("R5 pd at clock", pd, (k == 13) ? 1 : 0);
      srise();
    end
    sfall();
    chk("R5 pin floats at clock 14", oe, 0);
    chk("R5 stays powered down", pd, 1);
    srise();
    wake_check("R6");
    sfall();
    chk("R11 sample mode ignores clock oe", oe, 0);
    chk("R11 sample mode ignores clock hold", hold, 0);
    srise();
  endtask

  // Strobe raised mid-conversion and kept high: full-power finish (R7)
  task automatic t_full(input logic [11:0] w);
    start_conv(w);
    for (int k = 1; k <= 13; k++) begin
      sfall();
      chk("R7 pin driven", oe, 1);
      chk("R7 bit", data, exp_bit(w, k, 1'b0));
      srise();
      if (k == 4) begin
        conv = 1'b1;
        wait_n(6);
      end
    end
    chk("R7 no power-down", pd, 0);
    sfall();
    chk("R7 pin floats at clock 14", oe, 0);
    chk("R7 back to sample", hold, 0);
    chk("R7 full power", pd, 0);
    srise();
  endtask

  // Raise then lower during clock 13: LSB-first replay (R8 R9)
  task automatic t_lsb(input logic [11:0] w, input bit same_cycle);
    start_conv(w);
    for (int k = 1; k <= 12; k++) begin
      sfall();
      chk("R8 bit before replay", data, exp_bit(w, k, 1'b0));
      srise();
      if (k == 3) begin
        conv = 1'b1;
        wait_n(6);
      end
    end
    if (same_cycle) begin
      conv = 1'b0;
      sclk = 1'b0;
      wait_n(8);
    end else begin
      sclk = 1'b0;
      wait_n(4);
      conv = 1'b0;
      wait_n(6);
    end
    chk("R8 pin kept driven at clock 13", oe, 1);
    chk("R8 bit 0 kept", data, w[0]);
    chk("R8 power-down", pd, 1);
    srise();
    for (int k = 14; k <= 26; k++) begin
      sfall();
      if (k <= 24) begin
        chk("R8 lsb-first bit", data, exp_bit(w, k, 1'b1));
        chk("R8 pin driven", oe, 1);
      end else begin
        chk("R9 line held low", data, 0);
        chk("R9 pin still driven", oe, 1);
      end
      srise();
    end
    wake_check("R9");
  endtask

  // Raise then lower before clock 13: short-cycle abort (R10)
  task automatic t_short(input logic [11:0] w);
    start_conv(w);
    for (int k = 1; k <= 6; k++) begin
      sfall();
      chk("R10 bit before abort", data, exp_bit(w, k, 1'b0));
      srise();
      if (k == 3) begin
        conv = 1'b1;
        wait_n(6);
      end
    end
    conv = 1'b0;
    wait_n(6);
    chk("R10 pin floats at once", oe, 0);
    chk("R10 power-down", pd, 1);
    chk("R10 still holding", hold, 1);
    sfall();
    chk("R10 later clock ignored", oe, 0);
    srise();
    wake_check("R6 after abort");
  endtask

  initial begin
    t_reset();
    t_normal(12'h7FF);
    t_normal(12'h800);
    t_normal(12'hFFF);
    t_normal(12'hA5C);
    t_full(12'h3C6);
    t_lsb(12'hB29, 1'b0);
    t_lsb(12'h5D3, 1'b1);
    t_short(12'h9E1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule